// File: doc/BRIEF.md
# DMA Bus-Error Capture Unit

This block watches the bus master port of a multi-channel DMA engine for error responses. A transfer is in progress when `xferActive` is high, and `xferCh` then gives the channel that owns the transfer. If `busErr` arrives during a transfer and no earlier error is still held, the unit does four things. It clears every channel enable, so that the engine starts no new requests. It records the faulting channel in a status register. It raises an interrupt-style flag. It sends a one-cycle completion pulse, tagged with the channel, to the master controller, so that the controller finishes its sequence instead of waiting forever.

Only the first error is kept. While the status is valid, later errors are dropped and writes to the channel enables are refused. A DMA-local soft reset clears the status and puts the enables back to their default pattern. Full recovery of the surrounding subsystem also needs a soft reset of the master controller, which lies outside this unit. Software reads the captured information through a small read port with a one-bit selector.

Top module: `dma_err_capture`

## Requirements
- R1: After the asynchronous active-low reset, the status is invalid with channel 0, the enables equal the parameter `CH_EN_RESET` (all ones by default), and `errIrq` and `chDone` are low.
- R2: When `busErr` and `xferActive` are both high at a clock edge, no error is held, and no soft reset is requested, the next cycle shows the status valid, the channel equal to the sampled `xferCh`, and all enables at zero.
- R3: `errIrq` and `chDone` are high together for exactly the first cycle in which a newly captured status is visible, and `chDoneId` then equals the captured channel.
- R4: `busErr` while `xferActive` is low is ignored: the status, the enables and both pulses are unchanged.
- R5: While the status is valid, further bus errors leave the recorded channel unchanged and raise no pulse.
- R6: A write strobe `enWrStb` loads `enWrData` into the enables on the next cycle when no error is held. It is ignored while the status is valid.
- R7: If a capture and an enable write fall on the same edge, the capture wins and the enables become zero.
- R8: `dmaSoftRst` makes the next cycle show the status invalid, the channel 0 and the enables at `CH_EN_RESET`. It takes priority over a capture at the same edge, which then raises no pulse.
- R9: Read port: with `rdSel`=0, `rdData` carries the valid bit at bit 31 and the channel in the low `CH_W` bits, with all other bits zero. With `rdSel`=1, the enables appear in bits `NUM_CH-1:0` and all other bits are zero.
- R10: After a soft reset clears a held error, a new bus error is captured again, with fresh pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaSoftRst | input | 1 | DMA-local synchronous soft reset |
| xferActive | input | 1 | A bus transfer is in progress |
| xferCh | input | CH_W | Channel owning the current transfer |
| busErr | input | 1 | Error response from the bus |
| enWrStb | input | 1 | Channel-enable write strobe |
| enWrData | input | NUM_CH | Channel-enable write value |
| rdSel | input | 1 | Read selector: 0 status, 1 enables |
| chEnable | output | NUM_CH | Per-channel enables |
| errIrq | output | 1 | Error flag pulse |
| chDone | output | 1 | Completion pulse to the master controller |
| chDoneId | output | CH_W | Channel reported with the completion |
| rdData | output | REG_W | Read data |

## Verification
The directed part sets up the cases that a random mix rarely produces in isolation. These are an error with no transfer active, a second error while one is held, a write colliding with a capture, and a soft reset colliding with a capture. Each one separates the priority order between clear, capture and write. A long run from `$urandom` with a fixed seed then mixes transfers, errors, writes and soft resets at different rates. It compares every cycle against a bench-side model. This shows whether the first-error-only rule and the write lock hold across repeated error and recovery cycles, and on every channel index.

// File: rtl/bec_pkg.sv
package bec_pkg;
  // Strobes from control to datapath, evaluated for the coming edge.
  typedef struct packed {
    logic capture;  // latch error, drop enables
    logic clear;    // DMA soft reset
    logic enWrite;  // accepted enable write
  } becStrobes_t;
endpackage

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaSoftRst,
  input  logic        xferActive,
  input  logic        busErr,
  input  logic        enWrStb,
  input  logic        errValid,
  output becStrobes_t strobes,
  output logic        errIrq,
  output logic        chDone
);
  logic captureNow;

  // Clear outranks capture; capture outranks an enable write.
  always_comb begin
    captureNow      = busErr && xferActive && !errValid && !dmaSoftRst;
    strobes.clear   = dmaSoftRst;
    strobes.capture = captureNow;
    strobes.enWrite = enWrStb && !errValid && !captureNow && !dmaSoftRst;
  end

  // Both pulses line up with the first cycle of valid status.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errIrq <= 1'b0;
      chDone <= 1'b0;
    end else begin
      errIrq <= captureNow;
      chDone <= captureNow;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq); // R3
  AST_NO_PULSE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    dmaSoftRst |=> !errIrq && !chDone); // R8
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |=> !errIrq); // R4
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int REG_W  = 32,
  parameter logic [NUM_CH-1:0] CH_EN_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  becStrobes_t       strobes,
  input  logic [CH_W-1:0]   xferCh,
  input  logic [NUM_CH-1:0] enWrData,
  input  logic              rdSel,
  output logic              errValid,
  output logic [CH_W-1:0]   errCh,
  output logic [NUM_CH-1:0] chEnable,
  output logic [REG_W-1:0]  rdData
);
  localparam int VALID_BIT = REG_W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCh    <= '0;
      chEnable <= CH_EN_RESET;
    end else if (strobes.clear) begin
      errValid <= 1'b0;
      errCh    <= '0;
      chEnable <= CH_EN_RESET;
    end else if (strobes.capture) begin
      errValid <= 1'b1;
      errCh    <= xferCh;
      chEnable <= '0;
    end else if (strobes.enWrite) begin
      chEnable <= enWrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[NUM_CH-1:0] = chEnable;
    end else begin
      rdData[CH_W-1:0]   = errCh;
      rdData[VALID_BIT]  = errValid;
    end
  end

  AST_CAPTURE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> errValid && (chEnable == '0)); // R2
  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !strobes.clear |=> errValid && $stable(errCh)); // R5
  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> chEnable == '0); // R6
  AST_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> !errValid && (chEnable == CH_EN_RESET)); // R8
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import bec_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int REG_W  = 32,
  parameter logic [NUM_CH-1:0] CH_EN_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaSoftRst,
  input  logic              xferActive,
  input  logic [CH_W-1:0]   xferCh,
  input  logic              busErr,
  input  logic              enWrStb,
  input  logic [NUM_CH-1:0] enWrData,
  input  logic              rdSel,
  output logic [NUM_CH-1:0] chEnable,
  output logic              errIrq,
  output logic              chDone,
  output logic [CH_W-1:0]   chDoneId,
  output logic [REG_W-1:0]  rdData
);
  becStrobes_t     strobes;
  logic            errValid;
  logic [CH_W-1:0] errCh;

  bec_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .dmaSoftRst(dmaSoftRst), .xferActive(xferActive),
    .busErr(busErr), .enWrStb(enWrStb), .errValid(errValid),
    .strobes(strobes), .errIrq(errIrq), .chDone(chDone)
  );

  bec_datapath #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .REG_W(REG_W), .CH_EN_RESET(CH_EN_RESET)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .xferCh(xferCh),
    .enWrData(enWrData), .rdSel(rdSel), .errValid(errValid), .errCh(errCh),
    .chEnable(chEnable), .rdData(rdData)
  );

  assign chDoneId = errCh;

  AST_DONE_CARRIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    chDone |-> errValid && $rose(errValid)); // R3
endmodule

// File: tb/test_dma_err_capture.sv
module test_dma_err_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaSoftRst = 0, xferActive = 0, busErr = 0, enWrStb = 0, rdSel = 0;
  logic [CH_W-1:0]   xferCh = '0;
  logic [NUM_CH-1:0] enWrData = '0;
  logic [NUM_CH-1:0] chEnable;
  logic errIrq, chDone;
  logic [CH_W-1:0] chDoneId;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model
  logic mValid = 0;
  logic [CH_W-1:0] mCh = '0;
  logic [NUM_CH-1:0] mEn = '1;
  logic mPulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_err_capture i_dma_err_capture (
    .clk(clk), .rstN(rstN), .dmaSoftRst(dmaSoftRst), .xferActive(xferActive),
    .xferCh(xferCh), .busErr(busErr), .enWrStb(enWrStb), .enWrData(enWrData),
    .rdSel(rdSel), .chEnable(chEnable), .errIrq(errIrq), .chDone(chDone),
    .chDoneId(chDoneId), .rdData(rdData)
  );

  function automatic logic [31:0] expRead(input logic sel);
    logic [31:0] v = '0;
    if (sel) v[NUM_CH-1:0] = mEn;
    else begin
      v[CH_W-1:0] = mCh;
      v[31] = mValid;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepModel();
    logic cap;
    cap = busErr && xferActive && !mValid && !dmaSoftRst;
    mPulse = cap;
    if (dmaSoftRst) begin
      mValid = 0; mCh = '0; mEn = '1;
    end else if (cap) begin
      mValid = 1; mCh = xferCh; mEn = '0;
    end else if (enWrStb && !mValid) begin
      mEn = enWrData;
    end
  endtask

  task automatic cycle(input string tag, input logic sr, input logic be,
                       input logic act, input logic [CH_W-1:0] ch,
                       input logic wr, input logic [NUM_CH-1:0] wd, input logic sel);
    dmaSoftRst = sr; busErr = be; xferActive = act; xferCh = ch;
    enWrStb = wr; enWrData = wd; rdSel = sel;
    @(posedge clk);
    stepModel();
    @(negedge clk);
    chk(tag, 32'(chEnable), 32'(mEn));
    chk(tag, 32'(errIrq), 32'(mPulse));
    chk(tag, 32'(chDone), 32'(mPulse));
    if (mPulse) chk("R3", 32'(chDoneId), 32'(mCh));
    chk("R9", rdData, expRead(sel));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", 32'(chEnable), 32'hF);
    chk("R1", 32'(errIrq), 0);
    chk("R1", 32'(chDone), 0);
    chk("R1", rdData, 32'h0);
    rdSel = 1; #1;
    chk("R1", rdData, 32'h0000_000F);
    @(negedge clk);

    cycle("R6", 0, 0, 0, 0, 1, 4'b0110, 1);
    cycle("R4", 0, 1, 0, 3, 0, 0, 0);
    cycle("R2", 0, 1, 1, 2, 0, 0, 0);
    cycle("R3", 0, 0, 0, 0, 0, 0, 0);
    cycle("R5", 0, 1, 1, 1, 0, 0, 0);
    cycle("R6", 0, 0, 0, 0, 1, 4'b1111, 1);
    cycle("R8", 1, 0, 0, 0, 0, 0, 1);
    cycle("R8", 1, 1, 1, 3, 0, 0, 0);
    cycle("R7", 0, 1, 1, 1, 1, 4'b1011, 1);
    cycle("R8", 1, 0, 0, 0, 0, 0, 0);
    cycle("R10", 0, 1, 1, 3, 0, 0, 0);
    cycle("R10", 1, 0, 0, 0, 0, 0, 0);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      cycle("R6", ($urandom % 24) == 0, ($urandom % 6) == 0, $urandom % 2,
            CH_W'($urandom), ($urandom % 4) == 0, NUM_CH'($urandom), $urandom % 2);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule